// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Protocol Engine

This block is the bit-level slave front end of a 2048-byte serial memory. It oversamples the two bus lines on a fast system clock through a small synchroniser and finds clock edges, START conditions and STOP conditions. From these it runs the byte protocol: bits are shifted in or out MSB first, and the acknowledge is driven as an open-drain pull on the data line.

The first byte after a START is the device byte. It holds a fixed 4-bit type code, three block-select bits and a direction bit. In write direction the engine takes a word-address byte and then any number of data bytes. The address is sent to the external address pointer as a load strobe carrying the block bits joined to the word byte. Each data byte goes to the page buffer as a write strobe. A STOP that closes a write with at least one accepted byte pulses a commit strobe to the write sequencer.

In read direction the engine sends the byte the memory presents on its read-data input. It pulses a pointer-increment strobe for each byte and keeps going while the master acknowledges. A write-protect input refuses data bytes but not the addressing bytes. A busy input from the write sequencer keeps the engine silent to its own address while an internal write is running.

Top module: `eeprom_i2c_engine`

## Requirements
- R1: After reset the data line is released and no strobe is active. At most one of the four strobes (load, write, increment, commit) is high in any cycle.
- R2: A START (data falls while clock is high) begins reception of the device byte, MSB first. A device byte whose bits 7:4 equal 1010 is acknowledged while busy is low, by pulling the data line low during the ninth clock.
- R3: A device byte whose bits 7:4 differ from 1010 is not acknowledged. All following traffic up to the next START is ignored: no acknowledge and no strobe.
- R4: While busy is high, a matching device byte is not acknowledged and the rest of that transfer is ignored.
- R5: In write direction (device bit 0 = 0), the next byte is acknowledged. It produces one load pulse with address {device byte bits 3:1, word byte}.
- R6: With write-protect low, every following data byte is acknowledged and produces one write pulse carrying that byte.
- R7: With write-protect high, the device byte and the word byte are still acknowledged. Data bytes are not acknowledged and produce no write pulse.
- R8: A STOP (data rises while clock is high) after at least one accepted data byte pulses commit exactly once. A STOP with no accepted byte gives no commit. A repeated START before the STOP discards the pending commit.
- R9: In read direction (device bit 0 = 1), bytes come from the read-data input, MSB first. There is one increment pulse per byte sent, and a new byte follows each master acknowledge. The block bits of a read device byte are not used.
- R10: When the master does not acknowledge a read byte, the engine releases the data line and drives nothing more until the next START.
- R11: A START in the middle of any byte aborts it and restarts device-byte reception. A word-address write followed by a repeated START and a read returns data starting at that address.
- R12: The data-line pull changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| wp_i | input | 1 | Write-protect, high refuses data bytes |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Memory byte at the current pointer |
| ptr_load_o | output | 1 | One-cycle pulse: load pointer |
| ptr_addr_o | output | 11 | Address for the pointer load |
| ptr_inc_o | output | 1 | One-cycle pulse: a read byte was sent |
| wr_strobe_o | output | 1 | One-cycle pulse: data byte for page buffer |
| wr_data_o | output | 8 | Byte for the page buffer |
| commit_o | output | 1 | One-cycle pulse: start the internal write |

## Verification
The bench goes after the places where a slave most often goes wrong, using a bus master model with an open-drain data line.

The first is write protection. Refusing the device or word byte, instead of only the data bytes, would show up as missing acknowledges. A design that refuses the acknowledge but still writes would show a changed memory byte.

The second is the busy input and foreign type codes. A design that only blocks the first byte would go on to acknowledge or load on the bytes that follow.

The third is the read path. It checks random and current-address reads, and what happens after a master's not-acknowledge; a design that keeps driving would corrupt the extra clocked byte. It also checks that a repeated START drops a pending commit, and that a START in the middle of a byte resynchronises, which a design that keeps its bit count would miss.

A monitor watches the data pull while the clock is high throughout the run.

// File: rtl/eep_i2c_pkg.sv
package eep_i2c_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam int LAST_BIT = BYTE_W - 1;
    localparam int ACK_SLOT = BYTE_W;
    localparam int ACK_DONE = BYTE_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } eep_state_e;
endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sr;
        logic [STAGES-1:0] sda_sr;
        logic              scl_p;
        logic              sda_p;
    } smp_t;

    smp_t q, d;
    logic scl_s, sda_s;

    assign scl_s = q.scl_sr[STAGES-1];
    assign sda_s = q.sda_sr[STAGES-1];

    always_comb begin
        d        = q;
        d.scl_sr = {q.scl_sr[STAGES-2:0], scl_i};
        d.sda_sr = {q.sda_sr[STAGES-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o   = scl_s;
    assign sda_o   = sda_s;
    assign rise_o  = scl_s & ~q.scl_p;
    assign fall_o  = ~scl_s & q.scl_p;
    assign start_o = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_o  = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/eep_proto_ctrl.sv
module eep_proto_ctrl
    import eep_i2c_pkg::*;
#(
    parameter int                 BLK_W     = 3,
    parameter logic [6-BLK_W:0]   TYPE_CODE = 4'b1010,
    localparam int                ADDR_W    = BLK_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              rise,
    input  logic              fall,
    input  logic              start,
    input  logic              stop,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic              ptr_load_o,
    output logic [ADDR_W-1:0] ptr_addr_o,
    output logic              ptr_inc_o,
    output logic              wr_strobe_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              commit_o
);
    typedef struct packed {
        eep_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic              pull;
        logic              ack;
        logic              rw;
        logic [BLK_W-1:0]  blk;
        logic              wrote;
        logic              load;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [BYTE_W-1:0] wdat;
        logic              inc;
        logic              commit;
    } ctl_t;

    ctl_t q, d;
    logic [BYTE_W-1:0] byte_in;

    assign byte_in = {q.sh[BYTE_W-2:0], sda_s};

    always_comb begin
        d        = q;
        d.load   = 1'b0;
        d.wr     = 1'b0;
        d.inc    = 1'b0;
        d.commit = 1'b0;
        if (start) begin
            d.st    = ST_DEV;
            d.cnt   = '0;
            d.pull  = 1'b0;
            d.ack   = 1'b0;
            d.wrote = 1'b0;
        end else if (stop) begin
            d.st     = ST_IDLE;
            d.pull   = 1'b0;
            d.commit = q.wrote;
            d.wrote  = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (rise) begin
                if (q.cnt < CNT_W'(ACK_SLOT)) begin
                    d.cnt = q.cnt + 1'b1;
                    d.sh  = byte_in;
                    if (q.cnt == CNT_W'(LAST_BIT)) begin
                        d.ack = 1'b0;
                        case (q.st)
                            ST_DEV: begin
                                if (byte_in[BYTE_W-1:BLK_W+1] == TYPE_CODE && !busy_i) begin
                                    d.ack = 1'b1;
                                    d.rw  = byte_in[0];
                                    d.blk = byte_in[BLK_W:1];
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            ST_ADDR: begin
                                d.ack  = 1'b1;
                                d.load = 1'b1;
                                d.addr = {q.blk, byte_in};
                            end
                            ST_WDATA: begin
                                if (!wp_i) begin
                                    d.ack   = 1'b1;
                                    d.wr    = 1'b1;
                                    d.wdat  = byte_in;
                                    d.wrote = 1'b1;
                                end
                            end
                            default: d.inc = 1'b1;
                        endcase
                    end
                end else if (q.cnt == CNT_W'(ACK_SLOT)) begin
                    d.cnt = CNT_W'(ACK_DONE);
                    if (q.st == ST_RDATA) d.ack = ~sda_s;
                end
            end else if (fall) begin
                if (q.st == ST_RDATA) begin
                    if (q.cnt >= 1 && q.cnt <= CNT_W'(LAST_BIT)) begin
                        d.tx   = q.tx << 1;
                        d.pull = ~q.tx[BYTE_W-2];
                    end else if (q.cnt == CNT_W'(ACK_SLOT)) begin
                        d.pull = 1'b0;
                    end else if (q.cnt == CNT_W'(ACK_DONE)) begin
                        d.cnt = '0;
                        if (q.ack) begin
                            d.tx   = rd_data_i;
                            d.pull = ~rd_data_i[BYTE_W-1];
                        end else begin
                            d.st   = ST_IDLE;
                            d.pull = 1'b0;
                        end
                    end
                end else begin
                    if (q.cnt == CNT_W'(ACK_SLOT)) begin
                        d.pull = q.ack;
                    end else if (q.cnt == CNT_W'(ACK_DONE)) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        if (q.st == ST_DEV) begin
                            if (q.rw) begin
                                d.st   = ST_RDATA;
                                d.tx   = rd_data_i;
                                d.pull = ~rd_data_i[BYTE_W-1];
                            end else begin
                                d.st = ST_ADDR;
                            end
                        end else if (q.st == ST_ADDR) begin
                            d.st = ST_WDATA;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o  = q.pull;
    assign ptr_load_o  = q.load;
    assign ptr_addr_o  = q.addr;
    assign ptr_inc_o   = q.inc;
    assign wr_strobe_o = q.wr;
    assign wr_data_o   = q.wdat;
    assign commit_o    = q.commit;

    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.load, q.wr, q.inc, q.commit}));

    a_r5_load_from_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        q.load |-> $past(q.st) == ST_ADDR);

    a_r6_write_only_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> ($past(q.st) == ST_WDATA && !$past(wp_i)));

    a_r9_inc_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        q.inc |-> (q.st == ST_RDATA && q.rw));

    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_IDLE |-> !q.pull);

    a_r12_pull_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(q.pull));
endmodule

// File: rtl/eeprom_i2c_engine.sv
module eeprom_i2c_engine #(
    parameter int               SYNC_STAGES = 2,
    parameter int               BLK_W       = 3,
    parameter logic [6-BLK_W:0] TYPE_CODE   = 4'b1010,
    localparam int              ADDR_W      = BLK_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              ptr_load_o,
    output logic [ADDR_W-1:0] ptr_addr_o,
    output logic              ptr_inc_o,
    output logic              wr_strobe_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o
);
    logic scl_s, sda_s, rise, fall, start, stop;

    eep_line_sampler #(
        .STAGES (SYNC_STAGES)
    ) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_o   (scl_s),
        .sda_o   (sda_s),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start),
        .stop_o  (stop)
    );

    eep_proto_ctrl #(
        .BLK_W     (BLK_W),
        .TYPE_CODE (TYPE_CODE)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .rise        (rise),
        .fall        (fall),
        .start       (start),
        .stop        (stop),
        .wp_i        (wp_i),
        .busy_i      (busy_i),
        .rd_data_i   (rd_data_i),
        .sda_pull_o  (sda_pull_o),
        .ptr_load_o  (ptr_load_o),
        .ptr_addr_o  (ptr_addr_o),
        .ptr_inc_o   (ptr_inc_o),
        .wr_strobe_o (wr_strobe_o),
        .wr_data_o   (wr_data_o),
        .commit_o    (commit_o)
    );
endmodule

// File: tb/test_eeprom_i2c_engine.sv
`timescale 1ns/1ps
module test_eeprom_i2c_engine;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        wp = 1'b0;
    logic        busy = 1'b0;
    logic        sda_pull, ptr_load, ptr_inc, wr_strobe, commit;
    logic [10:0] ptr_addr;
    logic [7:0]  wr_data, rd_data;
    wire         sda_bus = m_sda & ~sda_pull;

    always #2.5 clk = ~clk;

    eeprom_i2c_engine i_eeprom_i2c_engine (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .wp_i(wp), .busy_i(busy), .rd_data_i(rd_data),
        .ptr_load_o(ptr_load), .ptr_addr_o(ptr_addr), .ptr_inc_o(ptr_inc),
        .wr_strobe_o(wr_strobe), .wr_data_o(wr_data), .commit_o(commit)
    );

    function automatic logic [7:0] fill(int i);
        return 8'(i * 37 + 11);
    endfunction

    // memory and pointer model driven by the strobes
    logic [7:0]  mem [0:2047];
    logic [10:0] ptr;
    logic [10:0] last_load;
    int n_load, n_wr, n_inc, n_commit;
    assign rd_data = mem[ptr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= fill(i);
            ptr <= '0; last_load <= '0;
            n_load <= 0; n_wr <= 0; n_inc <= 0; n_commit <= 0;
        end else begin
            if (ptr_load) begin
                ptr <= ptr_addr; last_load <= ptr_addr; n_load <= n_load + 1;
            end
            if (wr_strobe) begin
                mem[ptr] <= wr_data; ptr <= {ptr[10:5], ptr[4:0] + 5'd1}; n_wr <= n_wr + 1;
            end
            if (ptr_inc) begin
                ptr <= ptr + 11'd1; n_inc <= n_inc + 1;
            end
            if (commit) n_commit <= n_commit + 1;
        end
    end

    // R12 monitor: pull must not move while the clock line stays high
    int   viol = 0;
    logic scl_prev = 1'b1, pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && sda_pull != pull_prev) viol++;
        scl_prev  <= scl;
        pull_prev <= sda_pull;
    end

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; w(Q); scl = 1'b1; w(Q);
        m_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; w(Q); scl = 1'b1; w(Q); m_sda = 1'b1; w(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = v[i]; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        send_bits(v, 8);
        m_sda = 1'b1; w(Q); scl = 1'b1; w(Q);
        acked = ~sda_bus;
        w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            w(Q); scl = 1'b1; w(Q); b = {b[6:0], sda_bus}; w(Q); scl = 1'b0; w(Q);
        end
        m_sda = ~mack; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(Q); m_sda = 1'b1;
    endtask

    task automatic t_reset();
        chk(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
        chk({ptr_load, wr_strobe, ptr_inc, commit} == 4'b0, "R1 reset strobes",
            {ptr_load, wr_strobe, ptr_inc, commit}, 0);
    endtask

    task automatic t_write();
        bit a;
        int wr0 = n_wr, cm0 = n_commit;
        bus_start();
        send_byte(8'hA6, a); chk(a, "R2 device ack", a, 1);
        send_byte(8'h10, a); chk(a, "R5 word ack", a, 1);
        send_byte(8'hA5, a); chk(a, "R6 data ack", a, 1);
        send_byte(8'h3C, a); chk(a, "R6 data ack 2", a, 1);
        bus_stop();
        chk(last_load == 11'h310, "R5 load address", last_load, 'h310);
        chk(mem[11'h310] == 8'hA5, "R6 byte 0", mem[11'h310], 'hA5);
        chk(mem[11'h311] == 8'h3C, "R6 byte 1", mem[11'h311], 'h3C);
        chk(n_wr - wr0 == 2, "R6 write pulses", n_wr - wr0, 2);
        chk(n_commit - cm0 == 1, "R8 commit once", n_commit - cm0, 1);
    endtask

    task automatic t_protect();
        bit a;
        int wr0 = n_wr, cm0 = n_commit;
        wp = 1'b1;
        bus_start();
        send_byte(8'hA2, a); chk(a, "R7 device ack under wp", a, 1);
        send_byte(8'h40, a); chk(a, "R7 word ack under wp", a, 1);
        send_byte(8'h77, a); chk(!a, "R7 data refused", a, 0);
        bus_stop();
        wp = 1'b0;
        chk(n_wr == wr0, "R7 no write pulse", n_wr - wr0, 0);
        chk(mem[11'h140] == fill('h140), "R7 memory kept", mem[11'h140], fill('h140));
        chk(n_commit == cm0, "R8 no commit without data", n_commit - cm0, 0);
    endtask

    task automatic t_busy();
        bit a;
        int ld0 = n_load;
        busy = 1'b1;
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R4 busy silent", a, 0);
        send_byte(8'h00, a); chk(!a, "R4 rest ignored", a, 0);
        bus_stop();
        busy = 1'b0;
        chk(n_load == ld0, "R4 no load", n_load - ld0, 0);
    endtask

    task automatic t_foreign();
        bit a;
        int ld0 = n_load, wr0 = n_wr;
        bus_start();
        send_byte(8'hB0, a); chk(!a, "R3 foreign no ack", a, 0);
        send_byte(8'h12, a); chk(!a, "R3 byte ignored", a, 0);
        send_byte(8'h34, a); chk(!a, "R3 byte ignored 2", a, 0);
        bus_stop();
        chk(n_load == ld0 && n_wr == wr0, "R3 no strobes", (n_load - ld0) + (n_wr - wr0), 0);
    endtask

    task automatic t_random_read();
        bit a;
        logic [7:0] b;
        int in0 = n_inc;
        bus_start();
        send_byte(8'hA4, a); chk(a, "R11 device ack", a, 1);
        send_byte(8'hF0, a); chk(a, "R11 word ack", a, 1);
        bus_start();
        send_byte(8'hA5, a); chk(a, "R9 read device ack", a, 1);
        recv_byte(1'b1, b); chk(b == fill('h2F0), "R11 random byte 0", b, fill('h2F0));
        recv_byte(1'b1, b); chk(b == fill('h2F1), "R9 sequential byte 1", b, fill('h2F1));
        recv_byte(1'b0, b); chk(b == fill('h2F2), "R9 sequential byte 2", b, fill('h2F2));
        chk(sda_pull == 1'b0, "R10 released after nack", sda_pull, 0);
        recv_byte(1'b0, b); chk(b == 8'hFF, "R10 silent after nack", b, 'hFF);
        bus_stop();
        chk(n_inc - in0 == 3, "R9 increment pulses", n_inc - in0, 3);
    endtask

    task automatic t_current_read();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA1, a); chk(a, "R9 current read ack", a, 1);
        recv_byte(1'b0, b); chk(b == fill('h2F3), "R9 current address byte", b, fill('h2F3));
        bus_stop();
    endtask

    task automatic t_restart_discard();
        bit a;
        logic [7:0] b;
        int cm0 = n_commit;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h05, a);
        send_byte(8'h99, a); chk(a, "R6 data ack before restart", a, 1);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, b); chk(b == fill(6), "R11 read after restart", b, fill(6));
        bus_stop();
        chk(n_commit == cm0, "R8 restart drops commit", n_commit - cm0, 0);
    endtask

    task automatic t_abort();
        bit a;
        bus_start();
        send_bits(8'hFF, 5);
        bus_start();
        send_byte(8'hA0, a); chk(a, "R11 resync ack", a, 1);
        send_byte(8'h20, a); chk(a, "R11 resync word ack", a, 1);
        bus_stop();
        chk(last_load == 11'h020, "R11 resync load", last_load, 'h020);
    endtask

    initial begin
        w(5); rst_n = 1'b1; w(5);
        t_reset();
        t_write();
        t_protect();
        t_busy();
        t_foreign();
        t_random_read();
        t_current_read();
        t_restart_discard();
        t_abort();
        chk(viol == 0, "R12 pull moved with clock high", viol, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule